// File: doc/BRIEF.md
# Asymmetric Dual-Clock Simple Dual-Port RAM

This block is a storage array with one write-only port and one read-only port, each running on its own rising-edge clock. The two clocks are unrelated. The write side stores narrow 18-bit words at 1024 locations. The read side returns 36-bit words from 512 locations. Each wide word is built from two neighbouring narrow locations, so both ports see the same 18,432 bits through different widths.

The read side has an output register. When the read enable is high at a read-clock edge, the word at the sampled address appears on the output after that edge. When the enable is low, the output keeps its value. A synchronous read-side reset clears only the output register. Stored contents are not touched by it. A write and a read that hit the same location at about the same time in the two domains give undefined read data, so users must keep such accesses apart.

The storage is split into one lane bank per narrow slice of the wide word. A small decoder steers each narrow write to exactly one lane.

Top module: `asym_sdp_ram`

## Requirements
- R1: The write port has a 10-bit address covering 1024 locations of 18 bits. On a rising `wr_clk` edge with `wr_en` high, `wr_data` is stored at `wr_addr`. Locations 0 and 1023 are both writable.
- R2: The read port has a 9-bit address covering 512 locations of 36 bits.
- R3: Read word N carries write location 2N in bits [17:0] and write location 2N+1 in bits [35:18].
- R4: When `rd_en` is high at a rising `rd_clk` edge, `rd_data` shows the word at the sampled `rd_addr` right after that same edge, which is a latency of one read-clock cycle. Back-to-back enabled cycles return one word per cycle.
- R5: While `rd_en` is low at a rising `rd_clk` edge, `rd_data` keeps its previous value, whatever `rd_addr` does.
- R6: A `wr_clk` edge with `wr_en` low changes no stored location, even when `wr_addr` and `wr_data` are driven.
- R7: When `rd_rst_n` is low at a rising `rd_clk` edge, `rd_data` becomes all zeros after that edge. Stored contents are kept through the reset.
- R8: A write to one narrow location leaves the other half of the same wide word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock, rising edge |
| wr_en | input | 1 | Write strobe, active high |
| wr_addr | input | 10 | Narrow write location |
| wr_data | input | 18 | Narrow word to store |
| rd_clk | input | 1 | Read-side clock, rising edge, independent of wr_clk |
| rd_rst_n | input | 1 | Synchronous active-low clear of the output register |
| rd_en | input | 1 | Read strobe, active high |
| rd_addr | input | 9 | Wide read location |
| rd_data | output | 36 | Registered wide read word |

## Verification
The bench goes after the lane order inside a wide word. A swapped mapping would return the odd location in the low half, and a full readback of a pattern that is unique per location shows this at once. It writes a single odd location and reads its pair, which catches a decoder that strobes both lanes. A design with that bug would overwrite the even neighbour. It also drives idle write cycles that carry live address and data, which expose an enable that is ignored. On the read side it changes the address while the enable is low, to catch an output register that follows the address. It pulses the read reset between reads, to catch a reset that is missing or that wipes the array. The write addresses 0 and 1023 are covered, to catch an address that is cut off at the top or bottom of its range.

// File: rtl/asym_ram_pkg.sv
package asym_ram_pkg;

  // Which narrow slice of a wide word a write location feeds.
  function automatic int unsigned lane_of(input int unsigned waddr,
                                          input int unsigned ratio);
    return waddr % ratio;
  endfunction

  // Which wide row a write location belongs to.
  function automatic int unsigned row_of(input int unsigned waddr,
                                         input int unsigned ratio);
    return waddr / ratio;
  endfunction

  // Low bit position of a lane inside the wide read word.
  function automatic int unsigned lane_lsb(input int unsigned lane,
                                           input int unsigned narrow_w);
    return lane * narrow_w;
  endfunction

endpackage

// File: rtl/asym_wr_decode.sv
module asym_wr_decode
  import asym_ram_pkg::*;
#(
  parameter int unsigned WA    = 10,
  parameter int unsigned RA    = 9,
  parameter int unsigned RATIO = 2,
  localparam int unsigned LW   = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic [WA-1:0]    wr_addr,
  output logic [RATIO-1:0] lane_we,
  output logic [RA-1:0]    wr_row
);

  logic [LW-1:0] lane_sel;

  always_comb begin
    lane_sel = LW'(lane_of(32'(wr_addr), RATIO));
    wr_row   = RA'(row_of(32'(wr_addr), RATIO));
    lane_we  = '0;
    if (wr_en) begin
      lane_we[lane_sel] = 1'b1;
    end
  end

  // Checked at the write edge, where the strobes take effect.
  always_ff @(posedge wr_clk) begin
    // R8: a narrow write never strobes more than one lane
    assert_lane_onehot_R8: assert ($onehot0(lane_we))
      else $error("more than one lane strobed");
    // R6: a lane strobe exists exactly when the write enable is high
    assert_lane_follows_enable_R6: assert (wr_en == (|lane_we))
      else $error("lane strobe disagrees with write enable");
  end

endmodule

// File: rtl/asym_lane_bank.sv
module asym_lane_bank #(
  parameter int unsigned NW    = 18,
  parameter int unsigned RA    = 9,
  parameter int unsigned DEPTH = 512
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [RA-1:0] wr_row,
  input  logic [NW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en,
  input  logic [RA-1:0] rd_row,
  output logic [NW-1:0] rd_q
);

  logic [NW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) begin
      mem[wr_row] <= wr_data;
    end
  end

  always_ff @(posedge rd_clk) begin
    if (!rd_rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= mem[rd_row];
    end
  end

endmodule

// File: rtl/asym_sdp_ram.sv
module asym_sdp_ram
  import asym_ram_pkg::*;
#(
  parameter int unsigned NW       = 18,
  parameter int unsigned WR_DEPTH = 1024,
  parameter int unsigned RATIO    = 2,
  localparam int unsigned WW       = NW * RATIO,
  localparam int unsigned RD_DEPTH = WR_DEPTH / RATIO,
  localparam int unsigned WA       = $clog2(WR_DEPTH),
  localparam int unsigned RA       = $clog2(RD_DEPTH)
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [WA-1:0] wr_addr,
  input  logic [NW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_en,
  input  logic [RA-1:0] rd_addr,
  output logic [WW-1:0] rd_data
);

  logic [RATIO-1:0] lane_we;
  logic [RA-1:0]    wr_row;
  logic [NW-1:0]    lane_q [RATIO];

  asym_wr_decode #(
    .WA    (WA),
    .RA    (RA),
    .RATIO (RATIO)
  ) wr_dec_i (
    .wr_clk  (wr_clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .lane_we (lane_we),
    .wr_row  (wr_row)
  );

  for (genvar l = 0; l < RATIO; l++) begin : g_lane
    asym_lane_bank #(
      .NW    (NW),
      .RA    (RA),
      .DEPTH (RD_DEPTH)
    ) bank_i (
      .wr_clk   (wr_clk),
      .we       (lane_we[l]),
      .wr_row   (wr_row),
      .wr_data  (wr_data),
      .rd_clk   (rd_clk),
      .rd_rst_n (rd_rst_n),
      .rd_en    (rd_en),
      .rd_row   (rd_addr),
      .rd_q     (lane_q[l])
    );
    assign rd_data[lane_lsb(l, NW) +: NW] = lane_q[l];
  end

  // R5: an idle read cycle leaves the output register alone
  assert_hold_when_idle_R5: assert property (
    @(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |=> $stable(rd_data)
  ) else $error("read output moved without enable");

  // R7: one cycle after a sampled reset the output is cleared
  logic rst_seen_q;
  always_ff @(posedge rd_clk) begin
    if (rst_seen_q) begin
      assert_reset_clears_R7: assert (rd_data == '0)
        else $error("read output not cleared by reset");
    end
    rst_seen_q <= !rd_rst_n;
  end

endmodule

// File: tb/asym_sdp_ram_tb_top.sv
module asym_sdp_ram_tb_top;

  logic        wr_clk = 1'b0;
  logic        rd_clk = 1'b0;
  logic        wr_en  = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic        rd_rst_n = 1'b0;
  logic        rd_en  = 1'b0;
  logic [8:0]  rd_addr = '0;
  logic [35:0] rd_data;

  always #10 rd_clk = ~rd_clk;   // 50 MHz read clock
  always #13 wr_clk = ~wr_clk;   // unrelated write clock

  asym_sdp_ram dut_i (
    .wr_clk   (wr_clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [17:0] ref_mem [1024];
  logic [35:0] exp_q [$];
  string       tag_q [$];
  logic [35:0] last_exp;

  task automatic check(input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Bench view of the R3 mapping: odd location high, even location low.
  function automatic logic [35:0] wide_of(input int unsigned a);
    return {ref_mem[2*a+1], ref_mem[2*a]};
  endfunction

  task automatic wr_word(input int unsigned a, input logic [17:0] d,
                         input bit en);
    @(negedge wr_clk);
    wr_en   = en;
    wr_addr = 10'(a);
    wr_data = d;
    @(posedge wr_clk);
    if (en) ref_mem[a] = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  // Driver: one enabled read cycle, expectation pushed to the scoreboard.
  task automatic rd_push(input int unsigned a, input string req);
    @(negedge rd_clk);
    rd_en   = 1'b1;
    rd_addr = 9'(a);
    exp_q.push_back(wide_of(a));
    tag_q.push_back(req);
    last_exp = wide_of(a);
  endtask

  task automatic rd_idle(input int n);
    @(negedge rd_clk);
    rd_en = 1'b0;
    for (int i = 1; i < n; i++) @(negedge rd_clk);
  endtask

  // Monitor: one cycle after an enabled edge, compare against the queue.
  initial begin
    forever begin
      bit fire;
      @(posedge rd_clk);
      fire = rd_en && rd_rst_n;
      @(negedge rd_clk);
      if (fire) begin
        if (exp_q.size() == 0) begin
          n_checks++;
          n_fail++;
          $display("FAIL R4: got %h expected no output (queue empty)", rd_data);
        end else begin
          check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) ref_mem[i] = '0;
    repeat (3) @(negedge rd_clk);
    check("R7 reset state", rd_data, 36'h0);
    rd_rst_n = 1'b1;

    // Fill with a pattern unique per location (R1).
    for (int i = 0; i < 1024; i++)
      wr_word(i, 18'((i * 18'd613) ^ 18'h2A5C5), 1'b1);
    repeat (4) @(negedge rd_clk);

    // Full readback, back to back (R2, R3, R4).
    for (int a = 0; a < 512; a++) rd_push(a, "R3 full readback");
    rd_idle(1);

    // Hold with moving address (R5).
    for (int k = 0; k < 4; k++) begin
      @(negedge rd_clk);
      rd_addr = 9'(k * 97 + 3);
    end
    check("R5 hold while idle", rd_data, last_exp);

    // Isolated single read (R4).
    rd_push(7, "R4 single read latency");
    rd_idle(3);
    check("R5 hold after single read", rd_data, last_exp);

    // Disabled writes with live address and data (R6).
    wr_word(10, 18'h3FFFF, 1'b0);
    wr_word(11, 18'h15555, 1'b0);
    // Write only one odd location (R8) and the range ends (R1).
    wr_word(21, 18'h0BEEF, 1'b1);
    wr_word(0, 18'h12345, 1'b1);
    wr_word(1023, 18'h3ABCD, 1'b1);
    repeat (4) @(negedge rd_clk);

    rd_push(5, "R6 disabled write ignored");
    rd_push(10, "R8 partner lane kept");
    rd_push(0, "R1 lowest location");
    rd_push(511, "R1 highest location");
    rd_idle(2);

    // Read-side reset clears the output, keeps storage (R7).
    @(negedge rd_clk);
    rd_rst_n = 1'b0;
    @(negedge rd_clk);
    rd_rst_n = 1'b1;
    check("R7 output cleared", rd_data, 36'h0);
    rd_push(10, "R7 storage kept over reset");
    rd_push(255, "R7 storage kept over reset");
    rd_idle(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  end

endmodule